// File: doc/BRIEF.md
# Fault-atomic load-multiple sequencer

This block executes a load-multiple operation. It copies a run of consecutive memory words into a range of general registers. The range starts at a first register index, ends at a last register index, and wraps from 15 back to 0. A width mode selects one of three placements: a 32-bit word into the low half of each register, a 32-bit word into the high half, or a full 64-bit word. The word stride is 4 bytes in the two 32-bit modes and 8 bytes in the 64-bit mode.

The sequencer reads the first and the last word of the run before it writes any register. A fault on either end therefore leaves the whole register file untouched, and the operation can be restarted even if the base register is one of the destinations. Every middle address lies between two addresses that have already been checked, so the middle words are fetched only after both end reads succeed.

Memory is reached through a single-outstanding read request/response port that carries a fault flag. Results leave through a register-file write port with a two-bit half-lane enable, so the register half that is not loaded is never rewritten.

Top module: `ldm_sequencer`

## Requirements
- R1: The registers loaded are first_idx, first_idx+1, … up to last_idx, with indices taken mod 16. The count is ((last_idx - first_idx) mod 16) + 1, and each register in the range is written exactly once.
- R2: The k-th register of the range (k = 0 for first_idx) receives the word at base + stride*k. The stride is 4 when mode is 2'b00 or 2'b01, and 8 when mode is 2'b10 or 2'b11.
- R3: Reads are issued in this order: the first word, then the last word, then the middle words in ascending order. A one-register range issues exactly one read, and a two-register range issues exactly two.
- R4: No register write occurs until both end reads have returned without fault. Writes go in the order first register, last register, then the middle registers ascending.
- R5: A response with mem_rsp_fault high during an operation ends it. In the next cycle done and fault are both high for one cycle, busy is low, and no register is written by that operation.
- R6: In mode 2'b00, mem_rsp_data[31:0] goes to rf_data[31:0] with rf_lane = 2'b01. In mode 2'b01 it goes to rf_data[63:32] with rf_lane = 2'b10. In modes 2'b10 and 2'b11, all 64 bits are written with rf_lane = 2'b11. A half whose lane bit is low keeps its old value.
- R7: base_addr, first_idx, last_idx and mode are captured when start is accepted. Changes to these inputs during the operation have no effect.
- R8: Only one read is outstanding at a time. mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is seen. mem_rsp_data and mem_rsp_fault are ignored while mem_rsp_valid is low.
- R9: start is accepted only while busy is low. A start during an operation is ignored. A successful operation ends with a one-cycle done pulse with fault low, in the cycle after the last register write.
- R10: After reset, busy, done, fault, mem_req_valid and rf_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken when idle) |
| first_idx | input | 4 | First destination register |
| last_idx | input | 4 | Last destination register |
| base_addr | input | ADDR_W | Byte address of the first word |
| mode | input | 2 | 00 low half, 01 high half, 1x full 64-bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fault | output | 1 | High with done when the operation faulted |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | XLEN | Read data |
| mem_rsp_fault | input | 1 | Read faulted |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 4 | Register index written |
| rf_data | output | XLEN | Write data, already placed in its half |
| rf_lane | output | 2 | Half enables: bit 0 low half, bit 1 high half |

## Verification
A wrong offset counter or latched base shows up directly as a wrong mem_req_addr on the next accepted request, and the bench compares every request address against the expected order. A probe flag or phase that commits too early shows as an rf_we pulse before the second end response, and that is visible within one cycle. When fault injection is on, the same error shows as a modified register in the bench's own copy of the register file. A wrong lane or placement corrupts the preserved half of a register. That corruption is caught when the whole register file is compared after each done pulse.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_WR_FIRST, ST_WR_LAST, ST_WR_MID
  } lm_state_e;

  typedef enum logic [1:0] {
    PH_FIRST, PH_LAST, PH_MID
  } lm_phase_e;

  // mode[1] set selects the full-width transfer
  function automatic logic lm_is_full(input logic [1:0] m);
    return m[1];
  endfunction

  // log2 of the stride in bytes
  function automatic logic [1:0] lm_stride_log2(input logic [1:0] m);
    return lm_is_full(m) ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/ldm_addr_gen.sv
module ldm_addr_gen import ldm_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  ofs,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0] k,
                                                  input logic [1:0] m);
    return b + (ADDR_W'(k) << lm_stride_log2(m));
  endfunction

  assign addr = word_addr(base, ofs, mode);
endmodule

// File: rtl/ldm_lane_pack.sv
module ldm_lane_pack #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] word,
  input  logic [1:0]      mode,
  output logic [XLEN-1:0] data,
  output logic [1:0]      lane
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    if (mode[1]) begin
      data = word;
      lane = 2'b11;
    end else if (mode[0]) begin
      data = {word[HALF-1:0], {HALF{1'b0}}};
      lane = 2'b10;
    end else begin
      data = {{HALF{1'b0}}, word[HALF-1:0]};
      lane = 2'b01;
    end
  end
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl import ldm_pkg::*; #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first_in,
  input  logic [IDX_W-1:0] last_in,
  input  logic [1:0]       mode_in,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             rsp_fault,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_ofs,
  output logic             rsp_take,
  output logic             cap_first,
  output logic             cap_last,
  output logic             wr_en,
  output logic             wr_sel_last,
  output logic [IDX_W-1:0] wr_ofs,
  output logic [IDX_W-1:0] first_q,
  output logic [1:0]       mode_q,
  output logic             ends_ok
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  lm_state_e        state_q;
  lm_phase_e        phase_q;
  logic [IDX_W-1:0] ofs_q, span_q;
  logic             done_q, fault_q, ends_ok_q;

  assign accept      = (state_q == ST_IDLE) && start;
  assign busy        = (state_q != ST_IDLE);
  assign req_valid   = (state_q == ST_REQ);
  assign req_ofs     = ofs_q;
  assign rsp_take    = (state_q == ST_WAIT) && rsp_valid;
  assign cap_first   = rsp_take && !rsp_fault && (phase_q != PH_LAST);
  assign cap_last    = rsp_take && !rsp_fault && (phase_q == PH_LAST);
  assign wr_en       = (state_q == ST_WR_FIRST) || (state_q == ST_WR_LAST) ||
                       (state_q == ST_WR_MID);
  assign wr_sel_last = (state_q == ST_WR_LAST);
  assign wr_ofs      = (state_q == ST_WR_LAST)  ? span_q :
                       (state_q == ST_WR_FIRST) ? '0 : ofs_q;
  assign done        = done_q;
  assign fault       = fault_q;
  assign ends_ok     = ends_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_FIRST;
      ofs_q     <= '0;
      span_q    <= '0;
      first_q   <= '0;
      mode_q    <= '0;
      ends_ok_q <= 1'b0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          first_q   <= first_in;
          span_q    <= last_in - first_in;
          mode_q    <= mode_in;
          ofs_q     <= '0;
          phase_q   <= PH_FIRST;
          ends_ok_q <= 1'b0;
          state_q   <= ST_REQ;
        end
        ST_REQ: if (req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (rsp_fault) begin
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            case (phase_q)
              PH_FIRST: if (span_q == '0) begin
                ends_ok_q <= 1'b1;
                state_q   <= ST_WR_FIRST;
              end else begin
                phase_q <= PH_LAST;
                ofs_q   <= span_q;
                state_q <= ST_REQ;
              end
              PH_LAST: begin
                ends_ok_q <= 1'b1;
                state_q   <= ST_WR_FIRST;
              end
              default: state_q <= ST_WR_MID;
            endcase
          end
        end
        ST_WR_FIRST: if (span_q == '0) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_WR_LAST;
        end
        ST_WR_LAST: if (span_q == ONE) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          phase_q <= PH_MID;
          ofs_q   <= ONE;
          state_q <= ST_REQ;
        end
        ST_WR_MID: if (ofs_q == span_q - ONE) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          ofs_q   <= ofs_q + ONE;
          state_q <= ST_REQ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldm_sequencer.sv
module ldm_sequencer import ldm_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        mode,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  input  logic              mem_rsp_fault,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [XLEN-1:0]   rf_data,
  output logic [1:0]        rf_lane
);
  logic              accept, cap_first, cap_last, wr_sel_last;
  logic [IDX_W-1:0]  req_ofs, wr_ofs, first_q;
  logic [1:0]        mode_q;
  logic [ADDR_W-1:0] base_q;
  logic [XLEN-1:0]   hold_first, hold_last, wr_word;

  // named internal events for the checker
  logic ev_rsp_take, ev_ends_ok;

  ldm_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_in(first_idx), .last_in(last_idx), .mode_in(mode),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid), .rsp_fault(mem_rsp_fault),
    .accept(accept), .busy(busy), .done(done), .fault(fault),
    .req_valid(mem_req_valid), .req_ofs(req_ofs), .rsp_take(ev_rsp_take),
    .cap_first(cap_first), .cap_last(cap_last),
    .wr_en(rf_we), .wr_sel_last(wr_sel_last), .wr_ofs(wr_ofs),
    .first_q(first_q), .mode_q(mode_q), .ends_ok(ev_ends_ok)
  );

  // base captured once; later addresses never look at base_addr
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= base_addr;
  end

  // end-probe holding registers, committed only after both are clean
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_first <= '0;
      hold_last  <= '0;
    end else begin
      if (cap_first) hold_first <= mem_rsp_data;
      if (cap_last)  hold_last  <= mem_rsp_data;
    end
  end

  ldm_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base(base_q), .ofs(req_ofs), .mode(mode_q), .addr(mem_req_addr)
  );

  assign wr_word = wr_sel_last ? hold_last : hold_first;
  assign rf_idx  = first_q + wr_ofs;

  ldm_lane_pack #(.XLEN(XLEN)) u_pack (
    .word(wr_word), .mode(mode_q), .data(rf_data), .lane(rf_lane)
  );
endmodule

// File: rtl/ldm_sequencer_chk.sv
module ldm_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_fault,
  input logic              rf_we,
  input logic [1:0]        rf_lane,
  input logic              ev_rsp_take,
  input logic              ev_ends_ok
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
  AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_take && mem_rsp_fault |=> done && fault && !rf_we && !busy); // R5
  AST_COMMIT_AFTER_PROBES: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ev_ends_ok); // R4
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !rf_we); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R9
  AST_LANE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_lane != 2'b00); // R6
endmodule

bind ldm_sequencer ldm_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_ldm_sequencer.sv
`timescale 1ns/1ps
module test_ldm_sequencer;
  localparam int ADDR_W = 32;
  localparam int XLEN   = 64;
  localparam int NREG   = 16;

  typedef struct packed {
    logic [3:0]  r_first;
    logic [3:0]  r_last;
    logic [1:0]  md;
    logic [31:0] base;
    logic [1:0]  flt;   // 0 none, 1 fault on first word, 2 fault on last word
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  4'd5,  2'b00, 32'h0000_1000, 2'd0},
    '{4'd14, 4'd1,  2'b01, 32'h0000_2000, 2'd0},
    '{4'd7,  4'd7,  2'b10, 32'h0000_3000, 2'd0},
    '{4'd9,  4'd10, 2'b10, 32'h0000_3100, 2'd0},
    '{4'd0,  4'd15, 2'b00, 32'h0000_4000, 2'd0},
    '{4'd3,  4'd6,  2'b11, 32'h0000_5000, 2'd2},
    '{4'd12, 4'd2,  2'b00, 32'h0000_6000, 2'd1},
    '{4'd5,  4'd5,  2'b01, 32'h0000_7000, 2'd1},
    '{4'd4,  4'd11, 2'b01, 32'h0000_8000, 2'd0},
    '{4'd15, 4'd0,  2'b10, 32'h0000_9000, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start = 1'b0;
  logic [3:0]       first_idx = '0, last_idx = '0;
  logic [31:0]      base_addr = '0;
  logic [1:0]       mode = '0;
  logic             busy, done, fault, mem_req_valid, rf_we;
  logic             mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_fault = 1'b0;
  logic [31:0]      mem_req_addr;
  logic [63:0]      mem_rsp_data = '0, rf_data;
  logic [3:0]       rf_idx;
  logic [1:0]       rf_lane;

  ldm_sequencer #(.ADDR_W(ADDR_W), .XLEN(XLEN), .NREG(NREG)) i_ldm_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx), .last_idx(last_idx),
    .base_addr(base_addr), .mode(mode), .busy(busy), .done(done), .fault(fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .rf_lane(rf_lane)
  );

  int total = 0, bad = 0, cycles = 0;
  logic [63:0] rf_model [16];
  logic [31:0] rd_log [32];
  logic [3:0]  wr_log [32];
  int nreads = 0, nwrites = 0, done_cnt = 0;
  bit fault_seen = 0, pend = 0, flt_en = 0;
  logic [31:0] pend_addr = '0, flt_addr = '0;
  int rdy_cnt = 0;

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  // position k of the access order: first, last, then middles
  function automatic int order_ofs(input int k, input int span);
    if (k == 0) return 0;
    if (k == 1) return span;
    return k - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory model and observers, all away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 64'hBAD0_BAD0_BAD0_BAD0;   // junk while not valid (R8)
      mem_rsp_fault = 1'b1;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pend_addr);
        mem_rsp_fault = flt_en && (pend_addr == flt_addr);
        pend = 1'b0;
      end
      rdy_cnt++;
      mem_req_ready = (rdy_cnt % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        pend_addr = mem_req_addr;
        if (nreads < 32) rd_log[nreads] = mem_req_addr;
        nreads++;
      end
      if (rf_we) begin
        if (rf_lane[0]) rf_model[rf_idx][31:0]  = rf_data[31:0];
        if (rf_lane[1]) rf_model[rf_idx][63:32] = rf_data[63:32];
        if (nwrites < 32) wr_log[nwrites] = rf_idx;
        nwrites++;
      end
      if (done) begin
        done_cnt++;
        fault_seen = fault;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic run_vec(input vec_t v, input bit poke);
    logic [63:0] exp_rf [16];
    int span, stride, nexp_r, nexp_w, guard, cnt;
    bit ok;
    logic [31:0] a_bad;
    logic [63:0] w;
    span   = int'(4'(v.r_last - v.r_first));
    stride = v.md[1] ? 8 : 4;
    flt_en = (v.flt != 2'd0);
    flt_addr = v.base + ((v.flt == 2'd2) ? 32'(stride * span) : 32'd0);
    for (int i = 0; i < 16; i++) exp_rf[i] = rf_model[i];
    if (v.flt == 2'd0) begin
      for (int k = 0; k <= span; k++) begin
        w = mem_word(v.base + 32'(stride * k));
        if (v.md[1])      exp_rf[4'(v.r_first + 4'(k))] = w;
        else if (v.md[0]) exp_rf[4'(v.r_first + 4'(k))][63:32] = w[31:0];
        else              exp_rf[4'(v.r_first + 4'(k))][31:0]  = w[31:0];
      end
    end
    nexp_r = (v.flt == 2'd1) ? 1 : (v.flt == 2'd2) ? 2 : span + 1;
    nexp_w = (v.flt != 2'd0) ? 0 : span + 1;
    nreads = 0; nwrites = 0; done_cnt = 0; fault_seen = 0;

    @(negedge clk);
    start = 1'b1; first_idx = v.r_first; last_idx = v.r_last;
    base_addr = v.base; mode = v.md;
    @(negedge clk);
    start = 1'b0; base_addr = 32'hDEAD_BEE0; first_idx = ~v.r_first;
    last_idx = v.r_first; mode = ~v.md;                        // R7 inputs now junk
    if (poke) begin
      @(negedge clk); start = 1'b1;                            // R9 start while busy
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 600) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);

    chk(done_cnt == 1, "R9", "done pulse count", 64'(done_cnt), 64'd1);
    chk(fault_seen == (v.flt != 2'd0), "R5", "fault flag with done",
        64'(fault_seen), 64'(v.flt != 2'd0));
    chk(nreads == nexp_r, "R3", "number of reads", 64'(nreads), 64'(nexp_r));
    ok = 1'b1; a_bad = '0;
    for (int k = 0; k < nreads && k < nexp_r; k++)
      if (rd_log[k] != v.base + 32'(stride * order_ofs(k, span))) begin
        ok = 1'b0; a_bad = rd_log[k];
      end
    chk(ok, "R2/R7", "read address order", 64'(a_bad), 64'(v.base));
    chk(nwrites == nexp_w, (v.flt != 2'd0) ? "R5" : "R1", "number of writes",
        64'(nwrites), 64'(nexp_w));
    ok = 1'b1; cnt = 0;
    for (int k = 0; k < nwrites && k < nexp_w; k++)
      if (wr_log[k] != 4'(v.r_first + 4'(order_ofs(k, span)))) begin ok = 1'b0; cnt = k; end
    chk(ok, "R4", "write index order", 64'(wr_log[cnt]),
        64'(4'(v.r_first + 4'(order_ofs(cnt, span)))));
    ok = 1'b1; cnt = 0;
    for (int i = 0; i < 16; i++) if (rf_model[i] !== exp_rf[i]) begin ok = 1'b0; cnt = i; end
    chk(ok, (v.flt != 2'd0) ? "R5" : "R6", "register file contents",
        rf_model[cnt], exp_rf[cnt]);
    chk(!busy, "R9", "idle after done", 64'(busy), 64'd0);
    flt_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++)
      rf_model[i] = {32'hC0DE_0000 + 32'(i), 32'h0F0F_0000 + 32'(i)};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !fault, "R10", "status after reset",
        {61'd0, busy, done, fault}, 64'd0);
    chk(!mem_req_valid && !rf_we, "R10", "request/write after reset",
        {62'd0, mem_req_valid, rf_we}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < NV; n++) run_vec(VECS[n], n == 8);

    // directed: pair range faulting on the last word, then the same range clean
    run_vec('{4'd8, 4'd9, 2'b00, 32'h0000_A000, 2'd2}, 1'b0);   // R5 R3
    run_vec('{4'd8, 4'd9, 2'b01, 32'h0000_A000, 2'd0}, 1'b0);   // R6 R1
    // directed: full sixteen-register wrap in high mode, start poked while busy
    run_vec('{4'd6, 4'd5, 2'b01, 32'h0001_0000, 2'd0}, 1'b1);   // R1 R9
    finish_run();
  end
endmodule